// File: doc/BRIEF.md
# Two-Wire Wiper Register Slave

This block is the serial control front end of a 128-step digital potentiometer. It sits on a two-wire bus as a slave and holds a single volatile wiper register. A bus master can set that register with a one-byte write or read it back one or more times. All bus sampling is done on an internal system clock: the clock line and the data line are synchronized, edge-detected and decoded into START, STOP and bit events.

The slave answers to a fixed 7-bit identification code of 0x2E and has exactly one register, at address 0x00. It pulls the data line low through an open-drain enable and never drives it high. The wiper output carries the low seven bits of the register straight to the resistor ladder. For a fixed interval after reset the block ignores START conditions, so bus noise while power settles cannot start a transaction.

Top module: `wpot_i2c_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe_o` is 0 (line released) and `wiper_o` is 0x40.
- R2: A START that arrives within the first `PWRUP_CYCLES` system clocks after reset is ignored: no acknowledge follows and the wiper does not change.
- R3: An identification byte whose upper seven bits are 0x2E is acknowledged by pulling the data line low in the ninth clock. Any other code gets no acknowledge, and the slave stays silent until the next START.
- R4: The register address byte is acknowledged only when it equals 0x00. Any other value gets no acknowledge, and a following data byte leaves the wiper unchanged.
- R5: In a write (identification bit 0 = 0, address 0x00, data byte), the data byte is acknowledged and `wiper_o` takes its low seven bits. Bit 7 of the data byte is dropped. The update happens at the clock falling edge that ends the data LSB.
- R6: After the acknowledged data byte the slave is in standby. Further bytes before STOP get no acknowledge and do not change the wiper.
- R7: A read is: write identification, address 0x00, repeated START, identification with bit 0 = 1. All three bytes are acknowledged, and the slave then sends {0, wiper} MSB first.
- R8: While the master acknowledges in the ninth clock, the slave sends the same byte again. After a master non-acknowledge it releases the line and waits for STOP.
- R9: A read identification that is not preceded by an acknowledged address 0x00 since the last STOP gets no acknowledge.
- R10: A STOP in the middle of a byte aborts the transaction and leaves the wiper unchanged.
- R11: `sda_oe_o` changes only after a detected clock falling edge, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wiper_o | output | 7 | Current wiper tap |

## Verification
The bench runs random transactions of several kinds: valid writes with random data, writes with a wrong address or wrong identification, writes followed by extra bytes, reads of one to three bytes, and reads with no address phase. A bench model of the register predicts the value after each one. Valid and invalid writes show whether address and identification checking guards the register. Multi-byte reads show whether repeats stop correctly on a master non-acknowledge. Directed cases cover a START during the power-up window, a STOP in the middle of a byte, and data with bit 7 set. These separate power-up gating, abort handling and width truncation from the normal path.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DAT,
        ST_DAT_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } proto_st_e;

    typedef struct packed {
        proto_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rd;
        logic              addr_ok;
        logic              mack;
        logic              oe;
        logic [BYTE_W-2:0] wiper;
    } proto_s;
endpackage

// File: rtl/wpot_line_cond.sv
module wpot_line_cond #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev
);
    localparam int PIPE_W = SYNC_DEPTH + 1;

    logic [PIPE_W-1:0] scl_pipe_q, scl_pipe_d;
    logic [PIPE_W-1:0] sda_pipe_q, sda_pipe_d;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_pipe_q[PIPE_W-2];
    assign scl_prev = scl_pipe_q[PIPE_W-1];
    assign sda_now  = sda_pipe_q[PIPE_W-2];
    assign sda_prev = sda_pipe_q[PIPE_W-1];

    assign scl_rise = scl_now & ~scl_prev;
    assign scl_fall = ~scl_now & scl_prev;
    assign sda_s    = sda_now;
    assign start_ev = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/wpot_pwrup_gate.sv
module wpot_pwrup_gate #(
    parameter int PWRUP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic start_o
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          ready_q, ready_d;

    always_comb begin
        cnt_d   = cnt_q;
        ready_d = ready_q;
        if (!ready_q) begin
            if (cnt_q == CW'(PWRUP_CYCLES - 1)) ready_d = 1'b1;
            else                                cnt_d   = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            ready_q <= ready_d;
        end
    end

    assign start_o = start_i & ready_q;

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q);
endmodule

// File: rtl/wpot_proto.sv
module wpot_proto
    import wpot_pkg::*;
#(
    parameter logic [6:0] ID_CODE   = 7'h2E,
    parameter logic [6:0] WIPER_RST = 7'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic       start_ev,
    input  logic       stop_ev,
    output logic       sda_oe,
    output logic [6:0] wiper
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    proto_s q, d;
    logic [BYTE_W-1:0] tx_next;

    always_comb begin
        d       = q;
        tx_next = '0;
        if (stop_ev) begin
            d.st      = ST_IDLE;
            d.oe      = 1'b0;
            d.addr_ok = 1'b0;
            d.cnt     = '0;
        end else if (start_ev) begin
            d.st  = ST_ID;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_ID, ST_REG, ST_DAT: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        d.st  = ST_WAIT;
                        d.oe  = 1'b0;
                        if (q.st == ST_ID) begin
                            if (q.sh[BYTE_W-1:1] == ID_CODE && (!q.sh[0] || q.addr_ok)) begin
                                d.st = ST_ID_ACK;
                                d.oe = 1'b1;
                                d.rd = q.sh[0];
                            end
                        end else if (q.st == ST_REG) begin
                            if (q.sh == '0) begin
                                d.st      = ST_REG_ACK;
                                d.oe      = 1'b1;
                                d.addr_ok = 1'b1;
                            end else begin
                                d.addr_ok = 1'b0;
                            end
                        end else begin
                            d.wiper = q.sh[BYTE_W-2:0];
                            d.st    = ST_DAT_ACK;
                            d.oe    = 1'b1;
                        end
                    end
                end
                ST_ID_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.rd) begin
                            tx_next = {1'b0, q.wiper};
                            d.sh    = tx_next;
                            d.oe    = ~tx_next[BYTE_W-1];
                            d.cnt   = CNT_W'(1);
                            d.st    = ST_TX;
                        end else begin
                            d.st = ST_REG;
                        end
                    end
                end
                ST_REG_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_DAT;
                    end
                end
                ST_DAT_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WAIT;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe   = 1'b0;
                            d.cnt  = '0;
                            d.mack = 1'b0;
                            d.st   = ST_MACK;
                        end else begin
                            tx_next = {q.sh[BYTE_W-2:0], 1'b0};
                            d.sh    = tx_next;
                            d.oe    = ~tx_next[BYTE_W-1];
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            tx_next = {1'b0, q.wiper};
                            d.sh    = tx_next;
                            d.oe    = ~tx_next[BYTE_W-1];
                            d.cnt   = CNT_W'(1);
                            d.st    = ST_TX;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.wiper   <= WIPER_RST;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign wiper  = q.wiper;

    assert_oe_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall || start_ev || stop_ev));

    assert_wiper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.wiper) |-> $past(q.st == ST_DAT && scl_fall));

    assert_oe_states_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.st == ST_ID_ACK || q.st == ST_REG_ACK ||
                  q.st == ST_DAT_ACK || q.st == ST_TX));

    assert_mack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MACK) |-> !q.oe);
endmodule

// File: rtl/wpot_i2c_slave.sv
module wpot_i2c_slave #(
    parameter logic [6:0] ID_CODE      = 7'h2E,
    parameter logic [6:0] WIPER_RST    = 7'h40,
    parameter int         PWRUP_CYCLES = 64,
    parameter int         SYNC_DEPTH   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [6:0] wiper_o
);
    logic scl_rise, scl_fall, sda_s, start_raw, start_ok, stop_ev;

    wpot_line_cond #(.SYNC_DEPTH(SYNC_DEPTH)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_ev(start_raw), .stop_ev(stop_ev)
    );

    wpot_pwrup_gate #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .start_i(start_raw), .start_o(start_ok)
    );

    wpot_proto #(.ID_CODE(ID_CODE), .WIPER_RST(WIPER_RST)) u_proto (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_ev(start_ok), .stop_ev(stop_ev),
        .sda_oe(sda_oe_o), .wiper(wiper_o)
    );
endmodule

// File: tb/wpot_i2c_slave_bench.sv
module wpot_i2c_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b0;
    logic       m_low = 1'b0;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] wiper;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] exp_w = 7'h40;

    always #5 clk = ~clk;
    assign sda_bus = ~(m_low | sda_oe);

    wpot_i2c_slave u_wpot_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .wiper_o(wiper)
    );

    function automatic logic [7:0] id_byte(input logic rd);
        return {7'h2E, rd};
    endfunction

    function automatic logic [7:0] exp_tx(input logic [6:0] w);
        return {1'b0, w};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        m_low = ~b;
        wait_n(6);
        scl = 1'b1;
        wait_n(6);
        r = sda_bus;
        wait_n(6);
        scl = 1'b0;
        wait_n(6);
    endtask

    task automatic do_start();
        m_low = 1'b0;
        wait_n(6);
        scl = 1'b1;
        wait_n(6);
        m_low = 1'b1;
        wait_n(6);
        scl = 1'b0;
        wait_n(6);
    endtask

    task automatic do_stop();
        m_low = 1'b1;
        wait_n(6);
        scl = 1'b1;
        wait_n(6);
        m_low = 1'b0;
        wait_n(12);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            v[i] = r;
        end
        bit_io(~give_ack, r);
    endtask

    task automatic good_write(input logic [7:0] data);
        logic a;
        do_start();
        wr_byte(id_byte(1'b0), a); chk("R3 id ack", a, 1);
        wr_byte(8'h00, a);         chk("R4 addr ack", a, 1);
        wr_byte(data, a);          chk("R5 data ack", a, 1);
        do_stop();
        exp_w = data[6:0];
        chk("R5 wiper", wiper, exp_w);
    endtask

    task automatic good_read(input int nbytes);
        logic a;
        logic [7:0] v;
        do_start();
        wr_byte(id_byte(1'b0), a); chk("R7 id ack", a, 1);
        wr_byte(8'h00, a);         chk("R7 addr ack", a, 1);
        do_start();
        wr_byte(id_byte(1'b1), a); chk("R7 read id ack", a, 1);
        for (int k = 0; k < nbytes; k++) begin
            rd_byte(k != nbytes - 1, v);
            chk(k == 0 ? "R7 read data" : "R8 repeat data", v, exp_tx(exp_w));
        end
        chk("R8 released after nack", sda_oe, 0);
        do_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;
        logic [31:0] seed_v;
        seed_v = $urandom(32'd1234);
        wait_n(4);
        chk("R1 oe reset", sda_oe, 0);
        chk("R1 wiper reset", wiper, 7'h40);
        rst_n = 1'b1;

        // R2: transaction starting inside the power-up window
        m_low = 1'b0;
        scl = 1'b1;
        wait_n(2);
        m_low = 1'b1;
        wait_n(6);
        scl = 1'b0;
        wait_n(6);
        wr_byte(id_byte(1'b0), a); chk("R2 no ack in power-up", a, 0);
        wr_byte(8'h00, a);
        wr_byte(8'h11, a);
        do_stop();
        chk("R2 wiper unchanged", wiper, exp_w);
        wait_n(80);

        good_write(8'h25);
        good_write(8'hFF);   // R5 bit 7 dropped
        good_read(1);

        // R10 stop mid data byte
        do_start();
        wr_byte(id_byte(1'b0), a);
        wr_byte(8'h00, a);
        for (int i = 0; i < 4; i++) bit_io(1'b0, a);
        do_stop();
        chk("R10 abort keeps wiper", wiper, exp_w);

        // R9 read with no address phase
        do_start();
        wr_byte(id_byte(1'b1), a); chk("R9 read id nack", a, 0);
        do_stop();

        for (int t = 0; t < 36; t++) begin
            int kind;
            logic [7:0] rb;
            kind = $urandom_range(0, 5);
            rb = 8'($urandom);
            case (kind)
                0: good_write(rb);
                1: good_read($urandom_range(1, 3));
                2: begin
                    if (rb == 8'h00) rb = 8'h01;
                    do_start();
                    wr_byte(id_byte(1'b0), a); chk("R4 id ack", a, 1);
                    wr_byte(rb, a);            chk("R4 bad addr nack", a, 0);
                    wr_byte(8'h12, a);
                    do_stop();
                    chk("R4 wiper unchanged", wiper, exp_w);
                end
                3: begin
                    if (rb[7:1] == 7'h2E) rb[7:1] = 7'h2F;
                    do_start();
                    wr_byte(rb, a);    chk("R3 bad id nack", a, 0);
                    wr_byte(8'h00, a); chk("R3 silent after bad id", a, 0);
                    do_stop();
                    chk("R3 wiper unchanged", wiper, exp_w);
                end
                4: begin
                    good_write(rb);
                    do_start();
                    wr_byte(id_byte(1'b0), a);
                    wr_byte(8'h00, a);
                    wr_byte(rb ^ 8'h5A, a); chk("R5 data ack", a, 1);
                    wr_byte(8'h33, a);      chk("R6 extra byte nack", a, 0);
                    do_stop();
                    exp_w = 7'((rb ^ 8'h5A) & 8'h7F);
                    chk("R6 wiper keeps first byte", wiper, exp_w);
                end
                default: begin
                    do_start();
                    wr_byte(id_byte(1'b0), a);
                    wr_byte(8'h07, a);
                    do_start();
                    wr_byte(id_byte(1'b1), a); chk("R9 read after bad addr nack", a, 0);
                    do_stop();
                end
            endcase
        end
        rd_byte(1'b0, v);
        chk("R11 idle no drive", v, 8'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule